// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block turns a free-running oscillator clock into a repeating instruction cycle of four phases and hands the execute stage one 14-bit instruction word per cycle. Phase 1 through phase 4 each last one oscillator period, so a 4 MHz clock yields a 1 µs instruction time. The execute stage is told when to act by a one-period execute strobe in the fourth phase, and the word it should act on is held steady for the whole cycle.

Most instructions finish in one cycle. When the execute stage reports that a conditional test came out true, or that the program counter was rewritten, the word already fetched is stale. The sequencer then replaces the next cycle's instruction with the all-zero NOP, so the instruction that caused the change effectively takes two cycles, the second doing nothing.

The output side behaves as a fixed-rate stream: `exec_en` is the valid qualifier for `exec_insn`, and there is no ready input, because the instruction cycle is rigid and the execute stage must always accept. On the input side, `fetch_word` has no handshake either. It is sampled once per cycle at a single clock edge, and its value at any other time has no effect.

Top module: `qcyc_sequencer`

## Requirements
- R1: `phase_idx` steps 0,1,2,3,0,... on every clock after reset. Index 0 stands for the first phase and index 3 for the last. `phase_onehot` has exactly one bit set, and that bit is bit `phase_idx`.
- R2: A synchronous reset puts `phase_idx` at 0. The first cycle after reset is a flush cycle, with `flush_cycle`=1 and `exec_insn`=0x0000.
- R3: `exec_en` is 1 only while `phase_idx`=3. It is therefore high for exactly one clock out of every four, and this includes flush cycles.
- R4: `fetch_word` is captured at the clock edge that ends phase 3. In a non-flush cycle, `exec_insn` shows that word for all four phases of the following cycle. Changes to `fetch_word` at any other time do not affect it.
- R5: If `skip_taken` or `pc_changed` is 1 during phase 3 of a non-flush cycle, the next cycle is a flush cycle, with `flush_cycle`=1 and `exec_insn`=0x0000 (the NOP encoding).
- R6: `skip_taken` and `pc_changed` are ignored in phases 0 to 2. A pulse that falls before phase 3 does not cause a flush.
- R7: The strobes are ignored during a flush cycle, because a NOP cannot branch. Two flush cycles never follow each other except through reset.
- R8: When both strobes are high at once, they cause exactly one flush cycle, the same as either strobe alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per phase |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 14 | Instruction word from fetch, sampled at the end of phase 3 |
| skip_taken | input | 1 | Execute stage: conditional test true (sampled in phase 3) |
| pc_changed | input | 1 | Execute stage: program counter rewritten (sampled in phase 3) |
| phase_idx | output | 2 | Current phase number, 0 to 3 |
| phase_onehot | output | 4 | One-hot phase indicator |
| exec_en | output | 1 | Execute strobe, high during phase 3 |
| exec_insn | output | 14 | Instruction for the execute stage (NOP during a flush cycle) |
| flush_cycle | output | 1 | High for the whole of a forced-NOP cycle |

## Verification
Two functions can meet at the same phase-3 edge: the capture of the next fetched word, and the flush decision driven by a strobe. In one case the strobe arrives while the current cycle is itself a flush. That is provoked by holding both strobes high through a flush cycle's last phase, and it is judged by requiring the word captured at that edge to appear unmasked in the next cycle. Both strobes firing together is also driven, and it must give exactly one NOP cycle followed by the word fetched at the end of that NOP cycle.

// File: rtl/qcyc_pkg.sv
package qcyc_pkg;
  // Default geometry of the instruction cycle.
  localparam int unsigned QCYC_PHASES = 4;
  localparam int unsigned QCYC_INSN_W = 14;
endpackage

// File: rtl/qcyc_phase_gen.sv
module qcyc_phase_gen #(
  parameter int unsigned PHASES = qcyc_pkg::QCYC_PHASES,
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase_idx,
  output logic [PHASES-1:0] phase_oh,
  output logic            cycle_end
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] idx_q;
  logic            armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_q == LAST) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    armed_q <= ~rst;
  end

  genvar g;
  generate
    for (g = 0; g < PHASES; g++) begin : g_dec
      assign phase_oh[g] = (idx_q == PH_W'(g));
    end
  endgenerate

  assign phase_idx = idx_q;
  assign cycle_end = (idx_q == LAST);

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1))); // R1
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1); // R1
endmodule

// File: rtl/qcyc_flush_ctl.sv
module qcyc_flush_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cycle_end,
  input  logic skip_taken,
  input  logic pc_changed,
  output logic flush_q
);
  logic redirect;
  logic armed_q;

  assign redirect = skip_taken | pc_changed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= 1'b1;
    end else if (cycle_end) begin
      // A NOP cycle cannot redirect, so its strobes are dropped.
      flush_q <= ~flush_q & redirect;
    end
  end

  always_ff @(posedge clk) begin
    armed_q <= ~rst;
  end

  AST_FLUSH_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !flush_q && (skip_taken || pc_changed)) |=> flush_q); // R5
  AST_NO_DOUBLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && flush_q) |=> !flush_q); // R7
  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(cycle_end)) |-> $stable(flush_q)); // R6
endmodule

// File: rtl/qcyc_issue_stage.sv
module qcyc_issue_stage #(
  parameter int unsigned INSN_W = qcyc_pkg::QCYC_INSN_W,
  parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_end,
  input  logic              flush_q,
  input  logic [INSN_W-1:0] fetch_word,
  output logic [INSN_W-1:0] exec_insn
);
  logic [INSN_W-1:0] ir_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= NOP_WORD;
    end else if (cycle_end) begin
      ir_q <= fetch_word;
    end
  end

  always_ff @(posedge clk) begin
    armed_q <= ~rst;
  end

  assign exec_insn = flush_q ? NOP_WORD : ir_q;

  AST_INSN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !$past(cycle_end)) |-> $stable(exec_insn)); // R4
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> (ir_q == $past(fetch_word))); // R4
endmodule

// File: rtl/qcyc_sequencer.sv
module qcyc_sequencer #(
  parameter int unsigned PHASES = qcyc_pkg::QCYC_PHASES,
  parameter int unsigned INSN_W = qcyc_pkg::QCYC_INSN_W,
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic              skip_taken,
  input  logic              pc_changed,
  output logic [PH_W-1:0]   phase_idx,
  output logic [PHASES-1:0] phase_onehot,
  output logic              exec_en,
  output logic [INSN_W-1:0] exec_insn,
  output logic              flush_cycle
);
  localparam logic [INSN_W-1:0] NOP_WORD = '0;

  logic cycle_end;
  logic flush_q;
  logic armed_q;

  qcyc_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .phase_idx (phase_idx),
    .phase_oh  (phase_onehot),
    .cycle_end (cycle_end)
  );

  qcyc_flush_ctl u_flush (
    .clk        (clk),
    .rst        (rst),
    .cycle_end  (cycle_end),
    .skip_taken (skip_taken),
    .pc_changed (pc_changed),
    .flush_q    (flush_q)
  );

  qcyc_issue_stage #(.INSN_W(INSN_W), .NOP_WORD(NOP_WORD)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .cycle_end  (cycle_end),
    .flush_q    (flush_q),
    .fetch_word (fetch_word),
    .exec_insn  (exec_insn)
  );

  assign exec_en     = cycle_end;
  assign flush_cycle = flush_q;

  always_ff @(posedge clk) begin
    armed_q <= ~rst;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> (phase_idx == '0 && flush_cycle && exec_insn == NOP_WORD)); // R2
  AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> !exec_en); // R3
  AST_FLUSH_IS_NOP: assert property (@(posedge clk) disable iff (rst)
    flush_cycle |-> (exec_insn == NOP_WORD)); // R5
endmodule

// File: tb/qcyc_sequencer_tb.sv
module qcyc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] fetch_word = '0;
  logic        skip_taken = 1'b0;
  logic        pc_changed = 1'b0;
  logic [1:0]  phase_idx;
  logic [3:0]  phase_onehot;
  logic        exec_en;
  logic [13:0] exec_insn;
  logic        flush_cycle;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cyc    = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  qcyc_sequencer u_dut (
    .clk(clk), .rst(rst), .fetch_word(fetch_word),
    .skip_taken(skip_taken), .pc_changed(pc_changed),
    .phase_idx(phase_idx), .phase_onehot(phase_onehot),
    .exec_en(exec_en), .exec_insn(exec_insn), .flush_cycle(flush_cycle)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // advance one clock and settle just after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  // Run one cycle from phase 0; word is presented only in phase 3.
  task automatic run_cycle(input logic [13:0] w, input bit sk, input bit pc, input bit early);
    fetch_word = ~w;
    if (early) begin skip_taken = 1'b1; pc_changed = 1'b1; end
    tick(); tick(); tick();
    fetch_word = w;
    skip_taken = sk;
    pc_changed = pc;
    tick();
    skip_taken = 1'b0;
    pc_changed = 1'b0;
  endtask

  // Watch a whole cycle starting at phase 0: insn and flush held, strobe in phase 3.
  task automatic expect_cycle(input string req, input bit fl, input logic [13:0] insn);
    for (int p = 0; p < 4; p++) begin
      chk({req, " phase"}, int'(phase_idx), p);
      chk({req, " flush"}, int'(flush_cycle), int'(fl));
      chk({req, " insn"}, int'(exec_insn), int'(insn));
      if (p < 3) tick();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 phase after reset", int'(phase_idx), 0);
    chk("R2 flush after reset", int'(flush_cycle), 1);
    chk("R2 insn after reset", int'(exec_insn), 0);
    chk("R3 no exec in phase 0", int'(exec_en), 0);
  endtask

  task automatic t_period();
    do_reset();
    for (int i = 0; i < 12; i++) begin
      chk("R1 phase index", int'(phase_idx), i % 4);
      chk("R1 onehot", int'(phase_onehot), 1 << (i % 4));
      chk("R3 exec strobe", int'(exec_en), int'((i % 4) == 3));
      tick();
    end
  endtask

  task automatic t_normal();
    do_reset();
    run_cycle(14'h1A5C, 1'b0, 1'b0, 1'b0);      // flush cycle from reset
    chk("R4 word after reset flush", int'(exec_insn), 14'h1A5C);
    run_cycle(14'h2F0F, 1'b0, 1'b0, 1'b0);
    chk("R4 second word", int'(exec_insn), 14'h2F0F);
    fetch_word = 14'h3FFF;
    tick(); tick();
    chk("R4 insn ignores mid-cycle fetch", int'(exec_insn), 14'h2F0F);
  endtask

  task automatic t_skip_branch();
    do_reset();
    run_cycle(14'h0111, 1'b0, 1'b0, 1'b0);      // leave reset flush
    run_cycle(14'h0222, 1'b1, 1'b0, 1'b0);      // skip taken
    chk("R5 skip gives flush", int'(flush_cycle), 1);
    chk("R5 skip gives NOP", int'(exec_insn), 0);
    run_cycle(14'h0333, 1'b1, 1'b1, 1'b0);      // strobes in a flush cycle
    chk("R7 no back-to-back flush", int'(flush_cycle), 0);
    chk("R7 captured word shown", int'(exec_insn), 14'h0333);
    run_cycle(14'h0444, 1'b0, 1'b1, 1'b0);      // pc change alone
    expect_cycle("R5 pc change flush", 1'b1, 14'h0000);
    tick();
    run_cycle(14'h0555, 1'b0, 1'b0, 1'b0);
    run_cycle(14'h0666, 1'b1, 1'b1, 1'b0);      // both strobes, from normal cycle
    chk("R8 both strobes flush", int'(flush_cycle), 1);
    run_cycle(14'h0777, 1'b0, 1'b0, 1'b0);
    expect_cycle("R8 single flush only", 1'b0, 14'h0777);
    tick();
  endtask

  task automatic t_off_phase();
    do_reset();
    run_cycle(14'h1111, 1'b0, 1'b0, 1'b0);
    run_cycle(14'h1234, 1'b0, 1'b0, 1'b1);      // strobes only in phases 0-2
    expect_cycle("R6 early strobe ignored", 1'b0, 14'h1234);
    tick();
  endtask

  task automatic t_mid_reset();
    do_reset();
    run_cycle(14'h0ABC, 1'b0, 1'b0, 1'b0);
    tick(); tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R2 mid-run reset phase", int'(phase_idx), 0);
    chk("R2 mid-run reset flush", int'(flush_cycle), 1);
    chk("R2 mid-run reset insn", int'(exec_insn), 0);
  endtask

  initial begin
    t_reset();
    t_period();
    t_normal();
    t_skip_branch();
    t_off_phase();
    t_mid_reset();
    done = 1'b1;
    summary();
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", n_cyc);
      summary();
    end
  end
endmodule